// File: doc/BRIEF.md
# Subset Integer Instruction Executor

This block executes one 32-bit instruction word per clock from a small integer subset: register-register add, add with a signed immediate, load of a 16-bit constant into the upper half, and OR with an unsigned immediate. Each accepted word is decoded into its source, destination and immediate fields. The two source registers are read from a 32-entry register file, and the result is written back on the same clock edge that accepts the word.

A word is accepted only while its valid strobe is high. A word whose opcode or function value lies outside the subset raises a one-cycle illegal flag and writes nothing. A separate debug port reads any register through a registered output. The surrounding logic uses this port to observe the architectural state.

Top module: `int_subset_exec`

## Requirements
- R1: After synchronous reset, `illegal` is 0 and `dbg_data` is 0.
- R2: A word with opcode bits[31:26]=0 and function bits[5:0]=0x20 writes the sum of the registers at bits[25:21] and bits[20:16] into the register at bits[15:11]. The sum wraps modulo 2^32, and the shift field bits[10:6] is ignored.
- R3: Opcode 8 writes the register at bits[25:21] plus the sign-extended bits[15:0] into the register at bits[20:16]. The sum wraps with no trap.
- R4: Opcode 0x0F writes bits[15:0] into bits 31:16 of the register at bits[20:16] and clears its bits 15:0.
- R5: Opcode 0x0D writes the register at bits[25:21] ORed with the zero-extended bits[15:0] into the register at bits[20:16].
- R6: Register 0 always reads as zero. A write aimed at it leaves it at zero.
- R7: Any other opcode, or opcode 0 with a function value other than 0x20, raises `illegal` for exactly the following cycle and writes no register.
- R8: While `instr_valid` is low, no register changes and `illegal` stays low in the following cycle.
- R9: `dbg_data` shows the register selected by `dbg_addr` one clock later. If that register is written on the same edge, the old value is shown.
- R10: A word accepted in the cycle right after a write reads the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| dbg_addr | input | 5 | Register selected for the debug read |
| dbg_data | output | 32 | Registered contents of the selected register |
| illegal | output | 1 | Registered flag for an unsupported word |

## Verification
A word that is driven before edge N updates its destination register at edge N. `illegal` for that word is visible from edge N until edge N+1. The bench checks the flag at the falling edge that follows acceptance. It then presents the destination on `dbg_addr` and compares `dbg_data` one further falling edge later, because the debug port adds one register stage. The same-edge case and the back-to-back case each use their own directed sequence, so both timing boundaries are sampled at the cycle where they apply.

// File: rtl/ise_pkg.sv
package ise_pkg;
  localparam int WORD_W = 32;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 16;

  localparam logic [5:0] OPC_REGREG = 6'h00;
  localparam logic [5:0] OPC_ADDI   = 6'h08;
  localparam logic [5:0] OPC_ORI    = 6'h0D;
  localparam logic [5:0] OPC_LUI    = 6'h0F;
  localparam logic [5:0] FN_ADD     = 6'h20;

  typedef enum logic [2:0] {
    K_NONE, K_ADD, K_ADDI, K_ORI, K_LUI
  } op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic [REG_W-1:0]  src_a;
    logic [REG_W-1:0]  src_b;
    logic [REG_W-1:0]  dest;
    logic [WORD_W-1:0] imm;
    logic              legal;
  } dec_t;
endpackage

// File: rtl/ise_decode.sv
module ise_decode
  import ise_pkg::*;
(
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output dec_t              dec,
  output logic              wr_en,
  output logic              bad
);
  logic [5:0]       opc;
  logic [5:0]       fn;
  logic [IMM_W-1:0] imm16;

  assign opc   = word[31:26];
  assign fn    = word[5:0];
  assign imm16 = word[15:0];

  always_comb begin
    dec.kind  = K_NONE;
    dec.src_a = word[25:21];
    dec.src_b = word[20:16];
    dec.dest  = word[20:16];
    dec.imm   = '0;
    dec.legal = 1'b0;
    case (opc)
      OPC_REGREG: begin
        if (fn == FN_ADD) begin
          dec.kind  = K_ADD;
          dec.dest  = word[15:11];
          dec.legal = 1'b1;
        end
      end
      OPC_ADDI: begin
        dec.kind  = K_ADDI;
        dec.imm   = {{(WORD_W-IMM_W){imm16[IMM_W-1]}}, imm16};
        dec.legal = 1'b1;
      end
      OPC_ORI: begin
        dec.kind  = K_ORI;
        dec.imm   = {{(WORD_W-IMM_W){1'b0}}, imm16};
        dec.legal = 1'b1;
      end
      OPC_LUI: begin
        dec.kind  = K_LUI;
        dec.imm   = {imm16, {(WORD_W-IMM_W){1'b0}}};
        dec.legal = 1'b1;
      end
      default: ;
    endcase
  end

  assign wr_en = valid && dec.legal && (dec.dest != '0);
  assign bad   = valid && !dec.legal;
endmodule

// File: rtl/ise_alu.sv
module ise_alu
  import ise_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_kind_e          kind,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (kind)
      K_ADD:   res = a + b;
      K_ADDI:  res = a + imm;
      K_ORI:   res = a | imm;
      K_LUI:   res = imm;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/ise_regfile.sv
module ise_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : mem[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : mem[raddr_b];

  always_ff @(posedge clk) begin
    if (rst)                 dbg_data <= '0;
    else if (dbg_addr == '0) dbg_data <= '0;
    else                     dbg_data <= mem[dbg_addr];
  end
endmodule

// File: rtl/int_subset_exec.sv
module int_subset_exec
  import ise_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data,
  output logic              illegal
);
  dec_t              dec;
  logic              rf_we;
  logic              dec_bad;
  logic [DATA_W-1:0] opa, opb, result;

  ise_decode u_dec (
    .valid (instr_valid),
    .word  (instr_word),
    .dec   (dec),
    .wr_en (rf_we),
    .bad   (dec_bad)
  );

  ise_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (rf_we),
    .waddr    (dec.dest),
    .wdata    (result),
    .raddr_a  (dec.src_a),
    .rdata_a  (opa),
    .raddr_b  (dec.src_b),
    .rdata_b  (opb),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  ise_alu #(.DATA_W(DATA_W)) u_alu (
    .kind (dec.kind),
    .a    (opa),
    .b    (opb),
    .imm  (dec.imm),
    .res  (result)
  );

  always_ff @(posedge clk) begin
    if (rst) illegal <= 1'b0;
    else     illegal <= dec_bad;
  end
endmodule

// File: rtl/ise_checker.sv
module ise_checker (
  input logic        clk,
  input logic        rst,
  input logic        instr_valid,
  input logic [31:0] instr_word,
  input logic        wr_en,
  input logic [4:0]  wr_addr,
  input logic        illegal,
  input logic [31:0] dbg_data
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!illegal && dbg_data == 32'd0));

  // R7
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(!wr_en));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(instr_valid) |-> !illegal);

  // R8
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> !wr_en);

  // R6
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_addr != 5'd0);

  // R2
  add_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && instr_word[31:26] == 6'h00) |-> wr_addr == instr_word[15:11]);
endmodule

bind int_subset_exec ise_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr_word  (instr_word),
  .wr_en       (rf_we),
  .wr_addr     (dec.dest),
  .illegal     (illegal),
  .dbg_data    (dbg_data)
);

// File: tb/int_subset_exec_tb.sv
`timescale 1ns/1ps
module int_subset_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  logic        illegal;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl [32];
  bit done = 0;

  always #2.5 clk = ~clk;

  int_subset_exec dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .illegal(illegal)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  function automatic logic [31:0] enc_i(int opc, int rs, int rt, int imm);
    return {opc[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  // Reference behaviour from the requirements: legality, destination, value
  function automatic void model(input logic [31:0] w, output bit ok,
                                output int dst, output logic [31:0] val);
    logic [31:0] a, b;
    a = mdl[w[25:21]];
    b = mdl[w[20:16]];
    ok = 1; dst = int'(w[20:16]); val = '0;
    case (w[31:26])
      6'h00: if (w[5:0] == 6'h20) begin dst = int'(w[15:11]); val = a + b; end
             else ok = 0;
      6'h08: val = a + {{16{w[15]}}, w[15:0]};
      6'h0D: val = a | {16'h0, w[15:0]};
      6'h0F: val = {w[15:0], 16'h0};
      default: ok = 0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next one with the flag checked
  task automatic exec(string req, logic [31:0] w);
    bit ok; int dst; logic [31:0] val;
    model(w, ok, dst, val);
    instr_valid = 1'b1;
    instr_word = w;
    @(negedge clk);
    check(req, {31'b0, illegal}, {31'b0, !ok});
    if (ok && dst != 0) mdl[dst] = val;
  endtask

  task automatic peek(string req, int a);
    instr_valid = 1'b0;
    dbg_addr = a[4:0];
    @(negedge clk);
    check(req, dbg_data, mdl[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    foreach (mdl[i]) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", {31'b0, illegal}, 32'd0);
    check("R1", dbg_data, 32'd0);

    // R4 R5 initialise every register with lui then ori
    for (int r = 1; r < 32; r++) begin
      int hi = int'($urandom() & 32'hFFFF);
      int lo = int'($urandom() & 32'hFFFF);
      exec("R4", enc_i(15, 0, r, hi));
      exec("R5", enc_i(13, r, r, lo));
    end
    for (int r = 0; r < 32; r++) peek("R4", r);

    // R2 wrap and ignored shift field
    exec("R4", enc_i(15, 0, 1, 16'hFFFF));
    exec("R5", enc_i(13, 1, 1, 16'hFFFF));
    exec("R4", enc_i(15, 0, 2, 0));
    exec("R5", enc_i(13, 2, 2, 3));
    exec("R2", enc_r(1, 2, 3, 7, 32));
    peek("R2", 3);
    check("R2", mdl[3], 32'd2);
    // R3 negative immediate and wrap
    exec("R3", enc_i(8, 2, 4, 16'hFFFB));
    peek("R3", 4);
    check("R3", mdl[4], 32'hFFFF_FFFE);
    exec("R3", enc_i(8, 1, 5, 2));
    peek("R3", 5);
    // R5 zero-extension of a high-bit immediate
    exec("R5", enc_i(13, 0, 6, 16'h8001));
    peek("R5", 6);
    check("R5", mdl[6], 32'h0000_8001);
    // R4 low half cleared
    exec("R4", enc_i(15, 0, 7, 16'h1234));
    peek("R4", 7);
    check("R4", mdl[7], 32'h1234_0000);
    // R6 write to register 0 ignored, reads zero as source
    exec("R6", enc_i(15, 0, 0, 16'hABCD));
    peek("R6", 0);
    exec("R6", enc_r(0, 0, 8, 0, 32));
    peek("R6", 8);
    // R7 bad function and bad opcode
    exec("R7", enc_r(1, 2, 9, 0, 33));
    peek("R7", 9);
    check("R7", {31'b0, illegal}, 32'd0);
    exec("R7", enc_i(35, 1, 10, 4));
    peek("R7", 10);
    // R8 valid low: no write, no flag
    instr_word = enc_i(15, 0, 11, 16'h5555);
    instr_valid = 1'b0;
    @(negedge clk);
    check("R8", {31'b0, illegal}, 32'd0);
    instr_word = enc_i(2, 0, 11, 0);
    @(negedge clk);
    check("R8", {31'b0, illegal}, 32'd0);
    peek("R8", 11);
    // R9 same-edge read returns old value, next read the new one
    begin
      logic [31:0] old12;
      old12 = mdl[12];
      dbg_addr = 5'd12;
      exec("R9", enc_i(15, 0, 12, 16'h0F0F));
      check("R9", dbg_data, old12);
      peek("R9", 12);
    end
    // R10 back-to-back dependency
    exec("R10", enc_i(15, 0, 13, 16'h0001));
    exec("R10", enc_r(13, 13, 14, 0, 32));
    exec("R10", enc_i(8, 14, 15, 5));
    peek("R10", 14);
    peek("R10", 15);
    check("R10", mdl[15], 32'h0002_0005);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int k = int'($urandom_range(0, 5));
      int rs = int'($urandom_range(0, 31));
      int rt = int'($urandom_range(0, 31));
      int rd = int'($urandom_range(0, 31));
      int im = int'($urandom() & 32'hFFFF);
      logic [31:0] w;
      bit ok; int dst; logic [31:0] val;
      case (k)
        0: w = enc_r(rs, rt, rd, im & 31, 32);
        1: w = enc_i(8, rs, rt, im);
        2: w = enc_i(13, rs, rt, im);
        3: w = enc_i(15, rs, rt, im);
        4: w = enc_r(rs, rt, rd, 0, (im & 31) | 1);
        default: w = enc_i(int'($urandom_range(16, 63)), rs, rt, im);
      endcase
      model(w, ok, dst, val);
      exec(k == 0 ? "R2" : k == 1 ? "R3" : k == 2 ? "R5" : k == 3 ? "R4" : "R7", w);
      peek(ok ? "R9" : "R7", ok ? dst : rt);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule